// File: doc/BRIEF.md
# Two-Wire Serial Slave Memory

This block is a slave on a two-wire serial bus (I2C style) that gives a bus master access to a 512 x 8 memory array held inside the block. SCL and SDA are sampled on the system clock. SDA is open drain, so the block never drives it high: it has one output that, when asserted, pulls the line low. Two strap inputs set the device-select bits of the slave address. A write-protect input blocks every change to the array.

A write transfer carries the slave address, then one word-address byte, then any number of data bytes. Each data byte goes into the array as soon as its eighth bit arrives, so the block is never busy. A read transfer carries no word address. It continues from an internal 9-bit address latch. Bit 8 of that latch comes from the slave address byte, and bits 7:0 keep whatever the last access left in them. To read at a chosen address, the master first runs a write transfer that stops after the word address, then issues a repeated start and a read.

Top module: `twm_slave`

## Requirements
- R1: A start condition (SDA falls while SCL is high) at any point, including in the middle of a byte, resets the bit count and returns the block to slave-address reception with SDA released. A stop condition (SDA rises while SCL is high) releases SDA and leaves the block idle until the next start.
- R2: The slave address byte, sent MSB first, is 1010 in bits 7:4, then strap bit 1, strap bit 0, address bit A8 and the direction bit (bit 0; 0 = write, 1 = read). The block pulls SDA low in the ninth clock only when bits 7:4 equal 1010 and bits 3:2 equal the strap pins. On a mismatch it leaves SDA released, including through later bytes, until the next start.
- R3: In a write transfer, the first byte after the slave address is acknowledged and loads address bits 7:0. Bit 1 of the slave address byte loads address bit 8 in both directions.
- R4: In a write transfer, each data byte after the word address is stored at the latch address and acknowledged, and the latch then increments. A slave address sent right after a write, even through a repeated start, is always acknowledged.
- R5: A read transfer begins at the latch address with no word address. The block drives each byte MSB first, changes SDA only while SCL is low, and increments the latch after the eighth bit of each byte.
- R6: The address latch wraps from 1FFh to 000h, in both writes and reads.
- R7: In a read, an acknowledge from the master (SDA low in the ninth clock) makes the block send the next byte. A missing acknowledge (SDA high) ends the read and releases SDA.
- R8: While write protect is high, data bytes are not acknowledged, the array is unchanged and the latch does not increment. The slave address and word address are still acknowledged.
- R9: A start or stop condition before the eighth bit of a data byte discards that byte. The array and the latch keep their previous contents.
- R10: After reset, SDA is released and the address latch is 000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; SCL and SDA are oversampled on it |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Serial clock from the bus |
| sda_in | input | 1 | Level of the SDA line |
| sel_pins | input | 2 | Device-select straps compared with slave address bits 3:2 |
| wr_protect | input | 1 | High blocks writes to the array |
| sda_drive_low | output | 1 | High pulls SDA low; low releases the line |

## Verification
The assertions assume that every SCL phase lasts several system clocks longer than the synchronizer and edge-detect latency, which is about four cycles. They also assume the master changes SDA only while SCL is low, except when it makes a start or a stop, so the decoded start, stop and edge events match the real bus. The bench holds every bus level for six system clocks per quarter bit. It changes master SDA only in the low phase of SCL, except in its start and stop tasks. It models the open-drain line as the AND of the master level and the released slave output. Reset is held from time zero until after the first clock edges.

// File: rtl/twm_pkg.sv
package twm_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADDR,
    ST_DEVACK,
    ST_WADDR,
    ST_WADDRACK,
    ST_WDATA,
    ST_WDATAACK,
    ST_RDATA,
    ST_RACK
  } twm_state_e;
endpackage

// File: rtl/twm_bus_sync.sv
module twm_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_chain;
  logic [STAGES-1:0] sda_chain;
  logic              scl_d;
  logic              sda_d;

  generate
    if (STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= {scl_chain[STAGES-2:0], scl_in};
          sda_chain <= {sda_chain[STAGES-2:0], sda_in};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_chain <= '1;
          sda_chain <= '1;
        end else begin
          scl_chain <= scl_in;
          sda_chain <= sda_in;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_chain[STAGES-1];
      sda_d <= sda_chain[STAGES-1];
    end
  end

  assign scl_s     = scl_chain[STAGES-1];
  assign sda_s     = sda_chain[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/twm_array.sv
module twm_array #(
  parameter int ADDR_W = 9,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/twm_ctrl.sv
module twm_ctrl
  import twm_pkg::*;
#(
  parameter int          ADDR_W   = 9,
  parameter int          DATA_W   = 8,
  parameter logic [3:0]  DEV_CODE = 4'hA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [1:0]        sel_pins,
  input  logic              wr_protect,
  input  logic [DATA_W-1:0] rd_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] addr,
  output logic              sda_drive_low
);
  localparam int                 CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0]   FULL  = CNT_W'(DATA_W);
  localparam int                 LOW_W = ADDR_W - 1;
  localparam int                 MSB   = DATA_W - 1;

  twm_state_e        state;
  logic [CNT_W-1:0]  bitcnt;
  logic [DATA_W-1:0] shreg;
  logic [DATA_W-1:0] txreg;
  logic              rw;
  logic              mack;
  logic              dev_match;
  logic              inc_ev;

  assign dev_match = (shreg[MSB -: 4] == DEV_CODE) && (shreg[3:2] == sel_pins);

  assign inc_ev = scl_fall && !start_det && !stop_det && (bitcnt == FULL) &&
                  ((state == ST_WDATA && !wr_protect) || state == ST_RDATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      bitcnt        <= '0;
      shreg         <= '0;
      txreg         <= '0;
      rw            <= 1'b0;
      mack          <= 1'b0;
      addr          <= '0;
      sda_drive_low <= 1'b0;
      mem_we        <= 1'b0;
      mem_waddr     <= '0;
      mem_wdata     <= '0;
    end else begin
      mem_we <= 1'b0;
      if (start_det) begin
        state         <= ST_DEVADDR;
        bitcnt        <= '0;
        sda_drive_low <= 1'b0;
      end else if (stop_det) begin
        state         <= ST_IDLE;
        bitcnt        <= '0;
        sda_drive_low <= 1'b0;
      end else begin
        unique case (state)
          ST_DEVADDR, ST_WADDR, ST_WDATA: begin
            if (scl_rise && bitcnt != FULL) begin
              shreg  <= {shreg[MSB-1:0], sda_s};
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall && bitcnt == FULL) begin
              bitcnt <= '0;
              if (state == ST_DEVADDR) begin
                if (dev_match) begin
                  addr[ADDR_W-1] <= shreg[1];
                  rw             <= shreg[0];
                  sda_drive_low  <= 1'b1;
                  state          <= ST_DEVACK;
                end else begin
                  state <= ST_IDLE;
                end
              end else if (state == ST_WADDR) begin
                addr[LOW_W-1:0] <= shreg[LOW_W-1:0];
                sda_drive_low   <= 1'b1;
                state           <= ST_WADDRACK;
              end else begin
                if (!wr_protect) begin
                  mem_we        <= 1'b1;
                  mem_waddr     <= addr;
                  mem_wdata     <= shreg;
                  sda_drive_low <= 1'b1;
                end
                if (inc_ev) begin
                  addr <= addr + 1'b1;
                end
                state <= ST_WDATAACK;
              end
            end
          end
          ST_DEVACK: begin
            if (scl_fall) begin
              bitcnt <= '0;
              if (rw) begin
                txreg         <= rd_data;
                sda_drive_low <= ~rd_data[MSB];
                state         <= ST_RDATA;
              end else begin
                sda_drive_low <= 1'b0;
                state         <= ST_WADDR;
              end
            end
          end
          ST_WADDRACK, ST_WDATAACK: begin
            if (scl_fall) begin
              sda_drive_low <= 1'b0;
              bitcnt        <= '0;
              state         <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_rise && bitcnt != FULL) begin
              bitcnt <= bitcnt + 1'b1;
            end else if (scl_fall) begin
              if (bitcnt == FULL) begin
                sda_drive_low <= 1'b0;
                bitcnt        <= '0;
                if (inc_ev) begin
                  addr <= addr + 1'b1;
                end
                state <= ST_RACK;
              end else begin
                txreg         <= {txreg[MSB-1:0], 1'b0};
                sda_drive_low <= ~txreg[MSB-1];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                txreg         <= rd_data;
                sda_drive_low <= ~rd_data[MSB];
                state         <= ST_RDATA;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: begin
          end
        endcase
      end
    end
  end

  AST_START_REARM: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state == ST_DEVADDR && !sda_drive_low)); // R1
  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !sda_drive_low)); // R1
  AST_DRIVE_STATES: assert property (@(posedge clk) disable iff (rst)
    sda_drive_low |-> (state inside {ST_DEVACK, ST_WADDRACK, ST_WDATAACK, ST_RDATA})); // R2
  AST_DRIVE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_drive_low) |-> !scl_s); // R5
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (rst)
    inc_ev |=> (addr == $past(addr) + 1'b1)); // R6
  AST_WP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(!wr_protect)); // R8
endmodule

// File: rtl/twm_slave.sv
module twm_slave #(
  parameter int         ADDR_W      = 9,
  parameter int         DATA_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'hA
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [1:0] sel_pins,
  input  logic       wr_protect,
  output logic       sda_drive_low
);
  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_waddr;
  logic [DATA_W-1:0] mem_wdata;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] rd_data;

  twm_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twm_ctrl #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .DEV_CODE (DEV_CODE)
  ) u_ctrl (
    .clk           (clk),
    .rst           (rst),
    .scl_s         (scl_s),
    .sda_s         (sda_s),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .start_det     (start_det),
    .stop_det      (stop_det),
    .sel_pins      (sel_pins),
    .wr_protect    (wr_protect),
    .rd_data       (rd_data),
    .mem_we        (mem_we),
    .mem_waddr     (mem_waddr),
    .mem_wdata     (mem_wdata),
    .addr          (addr),
    .sda_drive_low (sda_drive_low)
  );

  twm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (addr),
    .rdata (rd_data)
  );
endmodule

// File: tb/twm_slave_bench.sv
module twm_slave_bench;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] sel_pins = 2'b10;
  logic       wr_protect = 1'b0;
  logic       sda_drive_low;
  logic       sda_line;

  int checks = 0;
  int errors = 0;

  logic [7:0] exp_q[$];
  logic [7:0] obs_q[$];
  string      tag_q[$];

  assign sda_line = sda_m & ~sda_drive_low;

  always #(CLK_PERIOD / 2) clk = ~clk;

  twm_slave u_twm_slave (
    .clk           (clk),
    .rst           (rst),
    .scl_in        (scl),
    .sda_in        (sda_line),
    .sel_pins      (sel_pins),
    .wr_protect    (wr_protect),
    .sda_drive_low (sda_drive_low)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n * QTR) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(1);
    scl = 1'b1; wq(1);
    sda_m = 1'b0; wq(1);
    scl = 1'b0; wq(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(1);
    scl = 1'b1; wq(1);
    sda_m = 1'b1; wq(1);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(1);
      scl = 1'b1; wq(2);
      scl = 1'b0; wq(1);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    send_bits(b, 8);
    sda_m = 1'b1; wq(1);
    scl = 1'b1; wq(1);
    acked = ~sda_line;
    wq(1);
    scl = 1'b0; wq(1);
  endtask

  task automatic send_expect(input logic [7:0] b, input bit exp_ack,
                             input string req, input string what);
    bit a;
    send_byte(b, a);
    chk(a == exp_ack, req, what, {15'd0, a}, {15'd0, exp_ack});
  endtask

  // driver: pushes expected byte, then clocks it out of the slave
  task automatic read_expect(input logic [7:0] exp, input bit give_ack,
                             input string req);
    logic [7:0] d;
    exp_q.push_back(exp);
    tag_q.push_back(req);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(1);
      scl = 1'b1; wq(1);
      d[i] = sda_line;
      wq(1);
      scl = 1'b0; wq(1);
    end
    sda_m = ~give_ack; wq(1);
    scl = 1'b1; wq(2);
    scl = 1'b0; wq(1);
    sda_m = 1'b1;
    obs_q.push_back(d);
  endtask

  // monitor: pops and compares
  initial begin
    forever begin
      logic [7:0] a;
      logic [7:0] e;
      string      t;
      wait (obs_q.size() > 0);
      a = obs_q.pop_front();
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5", "unexpected read byte", {8'd0, a}, 16'd0);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(a === e, t, "read data", {8'd0, a}, {8'd0, e});
      end
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(sda_drive_low == 1'b0, "R10", "released in reset", {15'd0, sda_drive_low}, 16'd0);
    rst = 1'b0;
    wq(2);
    chk(sda_drive_low == 1'b0, "R10", "released after reset", {15'd0, sda_drive_low}, 16'd0);

    // R10: latch starts at 000h; write there with no word address is not possible,
    // so read address 0 after writing it through a full write below.
    // R3/R4: write 11 22 33 44 at 0x010
    bus_start();
    send_expect(8'hA8, 1'b1, "R2", "matching slave write address");
    send_expect(8'h10, 1'b1, "R3", "word address");
    send_expect(8'h11, 1'b1, "R4", "data 0x010");
    send_expect(8'h22, 1'b1, "R4", "data 0x011");
    send_expect(8'h33, 1'b1, "R4", "data 0x012");
    send_expect(8'h44, 1'b1, "R4", "data 0x013");
    bus_start();
    send_expect(8'hA8, 1'b1, "R4", "no busy after write");
    bus_stop();
    wq(1);
    chk(sda_drive_low == 1'b0, "R1", "released after stop", {15'd0, sda_drive_low}, 16'd0);

    // R5/R7: random read from 0x010
    bus_start();
    send_expect(8'hA8, 1'b1, "R3", "slave address for random read");
    send_expect(8'h10, 1'b1, "R3", "load read address");
    bus_start();
    send_expect(8'hA9, 1'b1, "R2", "matching slave read address");
    read_expect(8'h11, 1'b1, "R5");
    read_expect(8'h22, 1'b1, "R7");
    read_expect(8'h33, 1'b0, "R7");
    wq(1);
    chk(sda_drive_low == 1'b0, "R7", "released after missing ack", {15'd0, sda_drive_low}, 16'd0);
    bus_stop();

    // R5: read continues from latch (0x013)
    bus_start();
    send_expect(8'hA9, 1'b1, "R5", "read with no word address");
    read_expect(8'h44, 1'b0, "R5");
    bus_stop();

    // R2: mismatches
    bus_start();
    send_expect(8'hA4, 1'b0, "R2", "strap mismatch");
    send_expect(8'hA8, 1'b0, "R2", "stays released until start");
    bus_stop();
    bus_start();
    send_expect(8'hB8, 1'b0, "R2", "device code mismatch");
    bus_stop();

    // R6: wrap 1FE,1FF,000
    bus_start();
    send_expect(8'hAA, 1'b1, "R3", "slave address with A8 set");
    send_expect(8'hFE, 1'b1, "R3", "word address 0xFE");
    send_expect(8'h5A, 1'b1, "R6", "data 0x1FE");
    send_expect(8'h6B, 1'b1, "R6", "data 0x1FF");
    send_expect(8'h7C, 1'b1, "R6", "data 0x000 after wrap");
    bus_stop();
    bus_start();
    send_expect(8'hAA, 1'b1, "R3", "slave address A8 set");
    send_expect(8'hFE, 1'b1, "R3", "reload 0xFE");
    bus_start();
    send_expect(8'hAB, 1'b1, "R2", "read with A8 set");
    read_expect(8'h5A, 1'b1, "R3");
    read_expect(8'h6B, 1'b1, "R6");
    read_expect(8'h7C, 1'b0, "R6");
    bus_stop();

    // R8: write protect
    wr_protect = 1'b1;
    bus_start();
    send_expect(8'hA8, 1'b1, "R8", "slave address under protect");
    send_expect(8'h10, 1'b1, "R8", "word address under protect");
    send_expect(8'h99, 1'b0, "R8", "protected data not acked");
    send_expect(8'h98, 1'b0, "R8", "second protected data not acked");
    bus_stop();
    wr_protect = 1'b0;
    bus_start();
    send_expect(8'hA9, 1'b1, "R8", "read after protected write");
    read_expect(8'h11, 1'b0, "R8");
    bus_stop();

    // R9: abort by stop and by repeated start
    bus_start();
    send_expect(8'hA8, 1'b1, "R9", "setup slave address");
    send_expect(8'h20, 1'b1, "R9", "setup word address");
    send_expect(8'hC3, 1'b1, "R9", "setup data");
    bus_stop();
    bus_start();
    send_expect(8'hA8, 1'b1, "R9", "slave address before abort");
    send_expect(8'h20, 1'b1, "R9", "word address before abort");
    send_bits(8'h00, 5);
    bus_stop();
    bus_start();
    send_expect(8'hA9, 1'b1, "R9", "read after stop abort");
    read_expect(8'hC3, 1'b0, "R9");
    bus_stop();
    bus_start();
    send_expect(8'hA8, 1'b1, "R9", "slave address before restart abort");
    send_expect(8'h20, 1'b1, "R9", "word address before restart abort");
    send_bits(8'h00, 4);
    bus_start();
    send_expect(8'hA9, 1'b1, "R1", "repeated start mid byte rearms");
    read_expect(8'hC3, 1'b0, "R9");
    bus_stop();

    // R10: latch reset to 000h (0x000 holds 0x7C from the wrap test)
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    wq(2);
    bus_start();
    send_expect(8'hA9, 1'b1, "R10", "read after reset");
    read_expect(8'h7C, 1'b0, "R10");
    bus_stop();

    wait (obs_q.size() == 0);
    wq(2);
    summary();
  end
endmodule